// File: doc/BRIEF.md
# Packed-Byte Pixel Arithmetic Unit

This unit performs single-instruction, multiple-data arithmetic on pixels. Each 32-bit word holds four byte lanes. The unit takes two 64-bit source pairs. A shared 2-bit byte offset picks a window of four consecutive bytes out of each pair, so pixel rows that do not start on a word boundary can be processed without a separate shift step. The two windows, called A and B, then feed one of five operations:

- a plain extract of window A;
- an unsigned saturating byte add;
- a signed saturating halfword add;
- a byte average, rounded or truncated;
- a subtract/absolute-value/accumulate step.

The subtract/absolute-value/accumulate step adds each lane's absolute difference into one of four 16-bit accumulators. This is the inner loop of sum-of-absolute-differences motion search. A controller streams one operation per cycle. It reads the packed result one cycle later and reads the accumulators at the end of a block. It pulses the clear input to start a new block.

Top module: `pix_simd_alu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `res_o` and `acc_o` are all zeros.
- R2: Byte k of a source pair is bits [8k+7:8k]. Lane i of a window is byte (ofs_i + i) of its pair, for lanes i = 0..3. With `op_i` = 0 (extract), `res_o` lane i (bits [8i+7:8i]) equals lane i of window A.
- R3: With `op_i` = 1, each result lane is the unsigned sum of the A and B lanes, clipped to 255.
- R4: With `op_i` = 2, lanes 1:0 form halfword 0 and lanes 3:2 form halfword 1, each two's complement. Each result halfword is A+B clipped to the range -32768..32767.
- R5: With `op_i` = 3 and `avg_trunc_i` = 0, each result lane is (A+B+1)>>1, computed without overflow.
- R6: With `op_i` = 3 and `avg_trunc_i` = 1, each result lane is (A+B)>>1.
- R7: With `op_i` = 4, each result lane is |A-B|. Accumulator i (bits [16i+15:16i] of `acc_o`) increases by that lane's |A-B|.
- R8: An accumulator that would exceed 0xFFFF holds at 0xFFFF and never wraps.
- R9: `acc_clr_i` high sets all four accumulators to 0 on the next edge. It takes priority over an accumulate issued in the same cycle.
- R10: When `op_i` is not 4 and `acc_clr_i` is low, the accumulators keep their values.
- R11: An `op_i` code of 5, 6 or 7 gives a zero result.
- R12: `res_o` and `acc_o` change at the first clock edge after the inputs are applied. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 extract, 1 add8, 2 add16, 3 average, 4 accumulate) |
| src_a_i | input | 64 | Source pair for window A |
| src_b_i | input | 64 | Source pair for window B |
| ofs_i | input | 2 | Byte offset of both windows |
| avg_trunc_i | input | 1 | Average truncates instead of rounding |
| acc_clr_i | input | 1 | Clear all accumulators |
| res_o | output | 32 | Registered packed result |
| acc_o | output | 64 | Four 16-bit accumulators, lane i at [16i+15:16i] |

## Verification
A wrong window index or a wrong clip shows up in `res_o` one cycle after the offending operation, and only in the lane concerned. Accumulator faults persist once they occur. A lost carry, a wrap past 0xFFFF, or an update during a non-accumulate operation stays visible on `acc_o` for every later cycle until the next clear. The bench therefore compares both outputs against the reference model on every clock. It deliberately runs one lane into saturation with hundreds of accumulate steps, and it issues a clear and an accumulate in the same cycle.

// File: rtl/pix_pkg.sv
package pix_pkg;
   typedef enum logic [2:0] {
      OP_EXTRACT = 3'd0,
      OP_ADD8    = 3'd1,
      OP_ADD16   = 3'd2,
      OP_AVG     = 3'd3,
      OP_SAA     = 3'd4
   } pix_op_e;
endpackage

// File: rtl/pix_align.sv
module pix_align #(
   parameter int LANES = 4,
   parameter int BW    = 8,
   localparam int OFSW = $clog2(LANES)
) (
   input  logic [2*LANES*BW-1:0] pair_i,
   input  logic [OFSW-1:0]       ofs_i,
   output logic [LANES*BW-1:0]   word_o
);
   logic [BW-1:0] bytes [2*LANES];

   generate
      if ((1 << OFSW) != LANES) begin : g_bad_lanes
         $error("pix_align: LANES must be a power of two");
      end
      for (genvar k = 0; k < 2*LANES; k++) begin : g_split
         assign bytes[k] = pair_i[k*BW +: BW];
      end
      for (genvar i = 0; i < LANES; i++) begin : g_pick
         logic [OFSW:0] sel;
         assign sel = {1'b0, ofs_i} + (OFSW+1)'(i);
         assign word_o[i*BW +: BW] = bytes[sel];
      end
   endgenerate
endmodule

// File: rtl/pix_lane.sv
module pix_lane #(
   parameter int BW = 8
) (
   input  logic [BW-1:0] a_i,
   input  logic [BW-1:0] b_i,
   input  logic          trunc_i,
   output logic [BW-1:0] sat_o,
   output logic [BW-1:0] avg_o,
   output logic [BW-1:0] abs_o
);
   logic [BW:0] sum;
   logic [BW:0] sum_r;

   assign sum   = {1'b0, a_i} + {1'b0, b_i};
   assign sat_o = sum[BW] ? {BW{1'b1}} : sum[BW-1:0];
   assign sum_r = sum + {{BW{1'b0}}, ~trunc_i};
   assign avg_o = sum_r[BW:1];
   assign abs_o = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
endmodule

// File: rtl/pix_saa_acc.sv
module pix_saa_acc #(
   parameter int BW   = 8,
   parameter int ACCW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            clr_i,
   input  logic [BW-1:0]   diff_i,
   output logic [ACCW-1:0] acc_o
);
   logic [ACCW:0] sum;

   generate
      if (ACCW <= BW) begin : g_bad_width
         $error("pix_saa_acc: ACCW must exceed BW");
      end
   endgenerate

   assign sum = {1'b0, acc_o} + (ACCW+1)'(diff_i);

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_o <= '0;
      else if (clr_i) acc_o <= '0;
      else if (en_i)  acc_o <= sum[ACCW] ? {ACCW{1'b1}} : sum[ACCW-1:0];
   end

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> acc_o == '0);
   // R10
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(acc_o));
   // R8
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && acc_o == {ACCW{1'b1}}) |=> acc_o == {ACCW{1'b1}});
   // R7
   monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i) |=> acc_o >= $past(acc_o));
endmodule

// File: rtl/pix_simd_alu.sv
module pix_simd_alu
   import pix_pkg::*;
#(
   parameter int LANES = 4,
   parameter int BW    = 8,
   parameter int ACCW  = 16,
   localparam int WW   = LANES*BW,
   localparam int PW   = 2*WW,
   localparam int HW   = 2*BW,
   localparam int OFSW = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [PW-1:0]     src_a_i,
   input  logic [PW-1:0]     src_b_i,
   input  logic [OFSW-1:0]   ofs_i,
   input  logic              avg_trunc_i,
   input  logic              acc_clr_i,
   output logic [WW-1:0]     res_o,
   output logic [LANES*ACCW-1:0] acc_o
);
   logic [WW-1:0] win_a, win_b;
   logic [WW-1:0] sat_w, avg_w, abs_w, add16_w;
   logic [WW-1:0] res_d;
   pix_op_e       op;
   logic          saa_en;

   assign op     = pix_op_e'(op_i);
   assign saa_en = (op_i == OP_SAA);

   generate
      if (LANES % 2 != 0) begin : g_bad_pairs
         $error("pix_simd_alu: LANES must be even for halfword adds");
      end
   endgenerate

   pix_align #(.LANES(LANES), .BW(BW)) u_align_a (
      .pair_i(src_a_i), .ofs_i(ofs_i), .word_o(win_a));
   pix_align #(.LANES(LANES), .BW(BW)) u_align_b (
      .pair_i(src_b_i), .ofs_i(ofs_i), .word_o(win_b));

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         pix_lane #(.BW(BW)) u_lane (
            .a_i(win_a[i*BW +: BW]), .b_i(win_b[i*BW +: BW]),
            .trunc_i(avg_trunc_i),
            .sat_o(sat_w[i*BW +: BW]), .avg_o(avg_w[i*BW +: BW]),
            .abs_o(abs_w[i*BW +: BW]));
         pix_saa_acc #(.BW(BW), .ACCW(ACCW)) u_acc (
            .clk(clk), .rst_n(rst_n), .en_i(saa_en), .clr_i(acc_clr_i),
            .diff_i(abs_w[i*BW +: BW]), .acc_o(acc_o[i*ACCW +: ACCW]));
      end
      for (genvar h = 0; h < LANES/2; h++) begin : g_half
         logic [HW-1:0] ha, hb;
         logic [HW:0]   hs;
         assign ha = win_a[h*HW +: HW];
         assign hb = win_b[h*HW +: HW];
         assign hs = {ha[HW-1], ha} + {hb[HW-1], hb};
         always_comb begin
            if (hs[HW] != hs[HW-1])
               add16_w[h*HW +: HW] = hs[HW] ? {1'b1, {(HW-1){1'b0}}}
                                            : {1'b0, {(HW-1){1'b1}}};
            else
               add16_w[h*HW +: HW] = hs[HW-1:0];
         end
      end
   endgenerate

   always_comb begin
      case (op)
         OP_EXTRACT: res_d = win_a;
         OP_ADD8:    res_d = sat_w;
         OP_ADD16:   res_d = add16_w;
         OP_AVG:     res_d = avg_w;
         OP_SAA:     res_d = abs_w;
         default:    res_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) res_o <= '0;
      else        res_o <= res_d;
   end

   // R11
   bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 3'd4) |=> res_o == '0);
   // R2
   extract_off0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0 && ofs_i == '0) |=> res_o == $past(src_a_i[WW-1:0]));
endmodule

// File: tb/tb_pix_simd_alu.sv
module tb_pix_simd_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic [63:0] src_a_i = '0, src_b_i = '0;
   logic [1:0]  ofs_i = '0;
   logic        avg_trunc_i = 1'b0, acc_clr_i = 1'b0;
   logic [31:0] res_o;
   logic [63:0] acc_o;

   int checks = 0, errors = 0;
   logic [31:0] exp_res = '0;
   int          m_acc [4] = '{0, 0, 0, 0};

   always #2.5 clk = ~clk;

   pix_simd_alu dut (.*);

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_acc();
      logic [63:0] v;
      for (int i = 0; i < 4; i++) v[16*i +: 16] = 16'(m_acc[i]);
      return v;
   endfunction

   task automatic step(int op, logic [63:0] a, logic [63:0] b, int ofs,
                       bit trunc, bit clr, string tag);
      int ab [4];
      int bb [4];
      op_i = 3'(op); src_a_i = a; src_b_i = b; ofs_i = 2'(ofs);
      avg_trunc_i = trunc; acc_clr_i = clr;
      for (int i = 0; i < 4; i++) begin
         ab[i] = int'((a >> (8*(ofs+i))) & 64'hFF);
         bb[i] = int'((b >> (8*(ofs+i))) & 64'hFF);
      end
      exp_res = '0;
      for (int i = 0; i < 4; i++) begin
         int d;
         d = (ab[i] > bb[i]) ? ab[i] - bb[i] : bb[i] - ab[i];
         case (op)
            0: exp_res[8*i +: 8] = 8'(ab[i]);
            1: exp_res[8*i +: 8] = 8'((ab[i] + bb[i] > 255) ? 255 : ab[i] + bb[i]);
            3: exp_res[8*i +: 8] = 8'((ab[i] + bb[i] + (trunc ? 0 : 1)) / 2);
            4: exp_res[8*i +: 8] = 8'(d);
            default: ;
         endcase
         if (clr) m_acc[i] = 0;
         else if (op == 4) m_acc[i] = (m_acc[i] + d > 65535) ? 65535 : m_acc[i] + d;
      end
      if (op == 2) begin
         for (int h = 0; h < 2; h++) begin
            int x, y, s;
            x = ab[2*h] + 256*ab[2*h+1]; if (x >= 32768) x -= 65536;
            y = bb[2*h] + 256*bb[2*h+1]; if (y >= 32768) y -= 65536;
            s = x + y;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            exp_res[16*h +: 16] = 16'(s);
         end
      end
      @(negedge clk);
      // R12: outputs compared one edge after inputs applied
      check({tag, " res"}, {32'h0, res_o}, {32'h0, exp_res});
      check({tag, " acc"}, acc_o, exp_acc());
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset res", {32'h0, res_o}, 64'h0);
      check("R1 reset acc", acc_o, 64'h0);
      rst_n = 1'b1;
      // R1: after reset release outputs still zero until first operation lands
      check("R1 post-reset res", {32'h0, res_o}, 64'h0);
      for (int o = 0; o < 4; o++)
         step(0, 64'h8877665544332211, 64'h0, o, 0, 0, "R2 extract");
      step(1, 64'h00000000_F0807F01, 64'h00000000_20807F01, 0, 0, 0, "R3 add8 clip");
      step(1, 64'hFF00000000000000, 64'h0200000000000000, 3, 0, 0, "R3 add8 high window");
      step(2, 64'h00000000_80007000, 64'h00000000_FF001000, 0, 0, 0, "R4 add16 clip");
      step(2, 64'h00000000_0001FFFF, 64'h00000000_00010002, 0, 0, 0, "R4 add16 plain");
      step(3, 64'h00000000_FF030201, 64'h00000000_FF000100, 0, 0, 0, "R5 avg round");
      step(3, 64'h00000000_FF030201, 64'h00000000_FF000100, 0, 1, 0, "R6 avg trunc");
      step(4, 64'h00000000_0A00FF10, 64'h00000000_05FF0020, 0, 0, 0, "R7 saa");
      step(4, 64'h1122334455667788, 64'h8877665544332211, 2, 0, 0, "R7 saa offset");
      step(1, 64'hFFFFFFFFFFFFFFFF, 64'h0, 0, 0, 0, "R10 hold add8");
      step(3, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1, 0, 0, "R10 hold avg");
      for (int c = 5; c < 8; c++)
         step(c, 64'hFFFFFFFFFFFFFFFF, 64'h1, 0, 0, 0, "R11 bad op");
      step(4, 64'hFFFFFFFFFFFFFFFF, 64'h0, 0, 0, 1, "R9 clear beats saa");
      step(0, 64'h0, 64'h0, 0, 0, 1, "R9 clear alone");
      for (int n = 0; n < 262; n++)
         step(4, 64'h00000000_FF00FF80, 64'h00000000_00FF0000, 0, 0, 0, "R8 saturate");
      step(4, 64'h00000000_FFFFFFFF, 64'h0, 0, 0, 0, "R8 stays at max");
      for (int n = 0; n < 300; n++) begin
         int op;
         op = int'($urandom % 8);
         step(op, {$urandom, $urandom}, {$urandom, $urandom}, int'($urandom % 4),
              bit'($urandom % 2), ($urandom % 16) == 0, $sformatf("R12 mixed op%0d", op));
      end
      finish_run();
   end
endmodule